// File: doc/BRIEF.md
# Memory Image Word-Sum Checksum Engine

This block walks a word-addressed non-volatile memory image through a simple read port and keeps a 16-bit running sum that wraps on overflow. The image is considered intact when the sum over every word from address 0 through the checksum word equals a fixed target constant (0xBABA by default). The checksum word therefore carries whatever value brings the total to the target, rather than to zero.

A single start pulse together with a mode select picks one of two operations. Check mode reads every word up to and including the checksum word and reports pass or fail. Fix mode reads the words below the checksum word, subtracts their sum from the target, and issues one word write of that value to the checksum address. Each read is issued as a one-cycle request carrying the address. The block then polls a response word until its done bit is set, and takes the data from the response's upper field. If no completion is seen within a fixed number of polls, the operation aborts and reports an error instead of a checksum verdict. A failed or missing write completion is reported the same way.

Top module: `nvm_csum_engine`

## Requirements
- R1: The sum is formed modulo 2^16: word values are added with carries out of bit 15 discarded.
- R2: In check mode (mode_sel = 0) the block reads addresses 0 through CSUM_ADDR in ascending order and finishes with pass when the sum equals TARGET, otherwise with fail; no write is issued.
- R3: In fix mode (mode_sel = 1) the block reads addresses 0 through CSUM_ADDR-1 in ascending order, then issues exactly one write of TARGET minus that sum to address CSUM_ADDR.
- R4: Each read is a rd_req pulse exactly one cycle wide with the address on rd_addr. The response rd_resp carries the done flag in bit 0 and the word in bits 16:1. Bits 16:1 are ignored while bit 0 is low.
- R5: If POLL_LIMIT consecutive polling cycles of a read pass without the done flag, the operation ends at once with err, and no further read or write is issued.
- R6: In fix mode, completion of the write (wr_ack) with wr_fail high, or POLL_LIMIT polling cycles without wr_ack, ends the operation with err; wr_ack with wr_fail low ends it with pass.
- R7: busy is high from the cycle after an accepted start until the cycle in which done pulses for one cycle. From that cycle on, exactly one of pass, fail and err is high, and it holds until the next accepted start.
- R8: A start pulse while busy is ignored: the running operation keeps its mode and produces its own result.
- R9: After reset busy, done, pass, fail, err, rd_req and wr_req are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| mode_sel | input | 1 | 0 check, 1 fix |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Check passed or fix write completed |
| fail | output | 1 | Check sum mismatch |
| err | output | 1 | Read or write error / timeout |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read word address |
| rd_resp | input | DW+1 | Read response: bit 0 done, bits DW:1 data |
| wr_req | output | 1 | One-cycle write request |
| wr_addr | output | AW | Write word address (always CSUM_ADDR) |
| wr_data | output | DW | Checksum value to write |
| wr_ack | input | 1 | Write completion |
| wr_fail | input | 1 | Write completed with error (valid with wr_ack) |

## Verification
The properties check the request discipline on every cycle. They cover the single-cycle width of rd_req, reads that stay at or below the checksum address, and writes that only target the checksum address. They also cover the link between the done pulse and the fall of busy, a single result flag at completion, a result that holds while idle, and silent ports after reset. The summed values, the wraparound, the exact write value, abort on a read timeout or failed write, and the rejection of a start while busy depend on memory contents and response timing. Only the bench scenarios can show those, driven by a responding memory model with random latencies and injected faults.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ISSUE = 3'd1,
    ST_RD_WAIT  = 3'd2,
    ST_WR_ISSUE = 3'd3,
    ST_WR_WAIT  = 3'd4
  } eng_state_t;

  typedef enum logic {
    MODE_CHECK = 1'b0,
    MODE_FIX   = 1'b1
  } eng_mode_t;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_PASS = 2'd1,
    RES_FAIL = 2'd2,
    RES_ERR  = 2'd3
  } eng_result_t;

endpackage

// File: rtl/nvm_csum_poll_timer.sv
// Counts polling cycles of one transfer; flags expiry on the LIMIT-th miss.
module nvm_csum_poll_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic waiting,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = arm | waiting;
    cnt_d  = arm ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = waiting && (cnt_q == LAST);

endmodule

// File: rtl/nvm_csum_accum.sv
// 16-bit (DW) wrapping word accumulator.
module nvm_csum_accum #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [DW-1:0] add_word,
  output logic [DW-1:0] sum,
  output logic [DW-1:0] sum_nxt
);
  logic [DW-1:0] sum_q, sum_d;
  logic          sum_en;

  assign sum_nxt = sum_q + add_word;

  always_comb begin
    sum_en = clr | add_en;
    sum_d  = clr ? '0 : sum_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;

endmodule

// File: rtl/nvm_csum_ctrl.sv
// Sequencer: read walk, verdict, optional checksum write.
module nvm_csum_ctrl
  import nvm_csum_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int          DW        = 16,
  parameter int          CSUM_ADDR = 63,
  parameter logic [15:0] TARGET    = 16'hBABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_sel,
  input  logic          rd_seen,
  input  logic          rd_expired,
  input  logic          wr_ack,
  input  logic          wr_fail,
  input  logic          wr_expired,
  input  logic [DW-1:0] sum_nxt,
  output logic          acc_clr,
  output logic          acc_add,
  output logic          rd_issue,
  output logic          rd_waiting,
  output logic          wr_issue,
  output logic          wr_waiting,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          err
);
  localparam bit            FIX_READS = (CSUM_ADDR != 0);
  localparam logic [AW-1:0] CHK_LAST  = AW'(CSUM_ADDR);
  localparam logic [AW-1:0] FIX_LAST  = AW'((CSUM_ADDR == 0) ? 0 : CSUM_ADDR - 1);
  localparam logic [DW-1:0] TGT       = DW'(TARGET);

  eng_state_t    state_q, state_d;
  eng_mode_t     mode_q, mode_d;
  eng_result_t   res_q, res_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [AW-1:0] last_addr;

  assign last_addr = (mode_q == MODE_FIX) ? FIX_LAST : CHK_LAST;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    res_d   = res_q;
    addr_d  = addr_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    acc_clr = 1'b0;
    acc_add = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          mode_d  = eng_mode_t'(mode_sel);
          addr_d  = '0;
          busy_d  = 1'b1;
          res_d   = RES_NONE;
          acc_clr = 1'b1;
          state_d = (mode_sel && !FIX_READS) ? ST_WR_ISSUE : ST_RD_ISSUE;
        end
      end
      ST_RD_ISSUE: state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (rd_seen) begin
          acc_add = 1'b1;
          if (addr_q == last_addr) begin
            if (mode_q == MODE_CHECK) begin
              state_d = ST_IDLE;
              busy_d  = 1'b0;
              done_d  = 1'b1;
              res_d   = (sum_nxt == TGT) ? RES_PASS : RES_FAIL;
            end else begin
              state_d = ST_WR_ISSUE;
            end
          end else begin
            addr_d  = addr_q + AW'(1);
            state_d = ST_RD_ISSUE;
          end
        end else if (rd_expired) begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
          res_d   = RES_ERR;
        end
      end
      ST_WR_ISSUE: state_d = ST_WR_WAIT;
      ST_WR_WAIT: begin
        if (wr_ack || wr_expired) begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
          res_d   = (wr_ack && !wr_fail) ? RES_PASS : RES_ERR;
        end
      end
      default: begin
        state_d = ST_IDLE;
        busy_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_CHECK;
      res_q   <= RES_NONE;
      addr_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      res_q   <= res_d;
      addr_q  <= addr_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign rd_issue   = (state_q == ST_RD_ISSUE);
  assign rd_waiting = (state_q == ST_RD_WAIT) && !rd_seen;
  assign wr_issue   = (state_q == ST_WR_ISSUE);
  assign wr_waiting = (state_q == ST_WR_WAIT) && !wr_ack;
  assign addr       = addr_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign pass       = (res_q == RES_PASS);
  assign fail       = (res_q == RES_FAIL);
  assign err        = (res_q == RES_ERR);

endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine #(
  parameter int          AW         = 6,
  parameter int          DW         = 16,
  parameter int          CSUM_ADDR  = 63,
  parameter logic [15:0] TARGET     = 16'hBABA,
  parameter int          POLL_LIMIT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_sel,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          err,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW:0]   rd_resp,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  input  logic          wr_fail
);
  localparam logic [DW-1:0] TGT = DW'(TARGET);

  logic          rd_seen;
  logic [DW-1:0] rd_word;
  logic          rd_issue, rd_waiting, rd_expired;
  logic          wr_issue, wr_waiting, wr_expired;
  logic          acc_clr, acc_add;
  logic [DW-1:0] sum, sum_nxt;
  logic [AW-1:0] addr;

  assign rd_seen = rd_resp[0];
  assign rd_word = rd_resp[DW:1];

  nvm_csum_ctrl #(
    .AW(AW), .DW(DW), .CSUM_ADDR(CSUM_ADDR), .TARGET(TARGET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .rd_seen(rd_seen), .rd_expired(rd_expired),
    .wr_ack(wr_ack), .wr_fail(wr_fail), .wr_expired(wr_expired),
    .sum_nxt(sum_nxt), .acc_clr(acc_clr), .acc_add(acc_add),
    .rd_issue(rd_issue), .rd_waiting(rd_waiting),
    .wr_issue(wr_issue), .wr_waiting(wr_waiting),
    .addr(addr), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .err(err)
  );

  nvm_csum_accum #(.DW(DW)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add_en(acc_add),
    .add_word(rd_word), .sum(sum), .sum_nxt(sum_nxt)
  );

  nvm_csum_poll_timer #(.LIMIT(POLL_LIMIT)) u_rd_timer (
    .clk(clk), .rst_n(rst_n), .arm(rd_issue), .waiting(rd_waiting),
    .expired(rd_expired)
  );

  nvm_csum_poll_timer #(.LIMIT(POLL_LIMIT)) u_wr_timer (
    .clk(clk), .rst_n(rst_n), .arm(wr_issue), .waiting(wr_waiting),
    .expired(wr_expired)
  );

  assign rd_req  = rd_issue;
  assign rd_addr = addr;
  assign wr_req  = wr_issue;
  assign wr_addr = AW'(CSUM_ADDR);
  assign wr_data = TGT - sum;

endmodule

// File: rtl/nvm_csum_engine_chk.sv
module nvm_csum_engine_chk #(
  parameter int AW        = 6,
  parameter int CSUM_ADDR = 63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          err,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr
);
  localparam logic [AW-1:0] CA = AW'(CSUM_ADDR);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_fall_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({pass, fail, err}));

  p_verdict_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({pass, fail, err}));

  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  p_rd_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr <= CA));

  p_wr_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_addr == CA));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req));

endmodule

bind nvm_csum_engine nvm_csum_engine_chk #(.AW(AW), .CSUM_ADDR(CSUM_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .fail(fail), .err(err), .rd_req(rd_req), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_addr(wr_addr)
);

// File: tb/nvm_csum_engine_bench.sv
module nvm_csum_engine_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 6;
  localparam int          DW         = 16;
  localparam int          CSUM_ADDR  = 63;
  localparam logic [15:0] TARGET     = 16'hBABA;
  localparam int          NWORDS     = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, mode_sel;
  logic          busy, done, pass, fail, err;
  logic          rd_req, wr_req;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW:0]   rd_resp;
  logic [DW-1:0] wr_data;
  logic          wr_ack, wr_fail;

  logic [15:0] mem [NWORDS];
  int          checks = 0, fails = 0;
  int          wr_count = 0;
  logic [15:0] last_wdata;
  logic [AW-1:0] last_waddr;
  bit          hang_rd_en = 0;
  int          hang_rd_addr = 0;
  bit          hang_wr_en = 0;
  bit          wr_fail_knob = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_csum_engine u_nvm_csum_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .err(err),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_resp(rd_resp),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_fail(wr_fail)
  );

  // read responder: done in bit 0, word in bits 16:1, random junk otherwise
  initial begin
    rd_resp = '0;
    forever begin
      @(negedge clk);
      rd_resp = {16'($urandom), 1'b0};
      if (rd_req) begin
        automatic int a = int'(rd_addr);
        automatic int lat = 1 + int'($urandom % 4);
        if (!(hang_rd_en && a == hang_rd_addr)) begin
          repeat (lat) @(negedge clk);
          rd_resp = {mem[a], 1'b1};
        end
      end
    end
  end

  // write responder
  initial begin
    wr_ack = 1'b0; wr_fail = 1'b0;
    forever begin
      @(negedge clk);
      wr_ack = 1'b0; wr_fail = 1'b0;
      if (wr_req) begin
        automatic int lat = 1 + int'($urandom % 3);
        wr_count++;
        last_wdata = wr_data;
        last_waddr = wr_addr;
        if (!hang_wr_en) begin
          repeat (lat) @(negedge clk);
          wr_ack = 1'b1;
          wr_fail = wr_fail_knob;
          if (!wr_fail_knob) mem[int'(last_waddr)] = last_wdata;
        end
      end
    end
  end

  function automatic logic [15:0] sum_upto(input int last);
    logic [15:0] s = 16'h0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // exp_res: 0 pass, 1 fail, 2 err
  task automatic run_op(input bit m, input bit poke_mid, input int exp_res,
                        input int exp_writes, input logic [15:0] exp_wdata,
                        input string req);
    int w0, n, got;
    w0 = wr_count;
    @(negedge clk);
    start = 1'b1; mode_sel = m;
    @(negedge clk);
    start = 1'b0; mode_sel = $urandom % 2;
    chk(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
      if (poke_mid && n == 40) start = 1'b1;
      else start = 1'b0;
      if (poke_mid && n == 40) mode_sel = ~m;
    end
    start = 1'b0;
    chk(n < 30000, req, "completion", n, 0);
    got = pass ? 0 : fail ? 1 : err ? 2 : 3;
    chk(got == exp_res, req, "verdict", got, exp_res);
    chk(busy == 1'b0, "R7", "busy at done", int'(busy), 0);
    chk(wr_count - w0 == exp_writes, req, "write count", wr_count - w0, exp_writes);
    if (exp_writes == 1) begin
      chk(last_wdata == exp_wdata, req, "write data", int'(last_wdata), int'(exp_wdata));
      chk(last_waddr == AW'(CSUM_ADDR), req, "write addr", int'(last_waddr), CSUM_ADDR);
    end
    @(negedge clk);
    chk(done == 1'b0, "R7", "done pulse width", int'(done), 0);
    got = pass ? 0 : fail ? 1 : err ? 2 : 3;
    chk(got == exp_res, "R7", "verdict held", got, exp_res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] s;
    void'($urandom(32'd2024));
    start = 1'b0; mode_sel = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < NWORDS; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk({busy, done, pass, fail, err, rd_req, wr_req} == 7'b0, "R9", "reset outputs",
        int'({busy, done, pass, fail, err, rd_req, wr_req}), 0);

    // R3 fix, then R2 check of fixed image passes
    s = TARGET - sum_upto(CSUM_ADDR - 1);
    run_op(1'b1, 1'b0, 0, 1, s, "R3");
    run_op(1'b0, 1'b0, 0, 0, 16'h0, "R2");
    // R2 corrupt one word -> fail
    mem[7] = mem[7] ^ 16'h0100;
    run_op(1'b0, 1'b0, 1, 0, 16'h0, "R2");

    // R1 wraparound: all ones with matching checksum
    for (int i = 0; i < CSUM_ADDR; i++) mem[i] = 16'hFFFF;
    mem[CSUM_ADDR] = 16'hBAF9;
    run_op(1'b0, 1'b0, 0, 0, 16'h0, "R1");
    mem[CSUM_ADDR] = 16'hFFFF;
    run_op(1'b0, 1'b0, 1, 0, 16'h0, "R1");
    run_op(1'b1, 1'b0, 0, 1, 16'hBAF9, "R1");

    // R5 read timeout in fix mode: error, no write
    for (int i = 0; i < NWORDS; i++) mem[i] = 16'($urandom);
    hang_rd_en = 1; hang_rd_addr = 5;
    run_op(1'b1, 1'b0, 2, 0, 16'h0, "R5");
    hang_rd_addr = CSUM_ADDR;
    run_op(1'b0, 1'b0, 2, 0, 16'h0, "R5");
    hang_rd_en = 0;

    // R6 write reported failure, then write timeout
    s = TARGET - sum_upto(CSUM_ADDR - 1);
    wr_fail_knob = 1;
    run_op(1'b1, 1'b0, 2, 1, s, "R6");
    wr_fail_knob = 0;
    hang_wr_en = 1;
    run_op(1'b1, 1'b0, 2, 1, s, "R6");
    hang_wr_en = 0;

    // R8 start while busy ignored: check run stays check mode (no write)
    s = sum_upto(CSUM_ADDR);
    run_op(1'b0, 1'b1, (s == TARGET) ? 0 : 1, 0, 16'h0, "R8");
    s = TARGET - sum_upto(CSUM_ADDR - 1);
    run_op(1'b1, 1'b1, 0, 1, s, "R8");

    // R4 random images and modes with random response latency/junk
    for (int it = 0; it < 24; it++) begin
      automatic bit m = $urandom % 2;
      for (int i = 0; i < NWORDS; i++) mem[i] = 16'($urandom);
      if ($urandom % 2) mem[CSUM_ADDR] = TARGET - sum_upto(CSUM_ADDR - 1);
      if (m) begin
        s = TARGET - sum_upto(CSUM_ADDR - 1);
        run_op(1'b1, 1'b0, 0, 1, s, "R4");
      end else begin
        s = sum_upto(CSUM_ADDR);
        run_op(1'b0, 1'b0, (s == TARGET) ? 0 : 1, 0, 16'h0, "R4");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule